// File: doc/BRIEF.md
# Runtime-Configurable Radix-2 FFT Engine

This block computes fixed-point complex discrete Fourier transforms, forward or inverse, over frames whose length is chosen while the chip runs. A single radix-2 butterfly works in place on a buffer of complex samples and completes one butterfly per clock. The twiddle factors come from a quarter-wave cosine table that is sized for the largest length. Smaller lengths step through that table with a wider stride, so one table serves every length. Each stage halves its results with rounding, so a transform of N points returns the DFT divided by N in both directions. Results saturate rather than wrap.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. On either stream a beat transfers only in a cycle where both valid and ready are high. The block lowers `in_ready` whenever it has no room for the next sample. While `out_valid` is high and `out_ready` is low, the output beat stays on the pins unchanged. A one-cycle `done` pulse closes each frame.

Plain configuration pins set four things: the length exponent, the direction, the decimation style (time or frequency), and whether frames run strictly one at a time or overlap through two buffers. A configuration write only takes effect when the engine holds no data. Any other write is dropped and sets a sticky error flag. In decimation-in-time the engine stores the input at bit-reversed addresses. In decimation-in-frequency it reads the output through the bit-reversed index. In both cases the sample order at the ports is natural.

Top module: `fft_engine`

## Requirements
- R1: With length exponent L (N = 2^L), a frame takes exactly N input beats and returns exactly N output beats. `done` is high for exactly one cycle, namely the cycle after the final output beat. That cycle has `out_valid` low in discrete mode.
- R2: With `cfg_inverse`=0 and `cfg_dif`=0, output beat k carries (1/N)·Σ x[n]·e^(−j2πnk/N) for k = 0..N−1 in natural order, within ±3 LSB on each of the real and imaginary parts.
- R3: With `cfg_inverse`=1, output beat k carries (1/N)·Σ x[n]·e^(+j2πnk/N), with the same order and tolerance as R2.
- R4: With `cfg_dif`=1 (decimation in frequency), the results at the ports obey R2/R3 with the same natural order and tolerance as with `cfg_dif`=0.
- R5: With `cfg_stream`=0 (discrete), `in_ready` is low from the last input beat of a frame until that frame's `done`. With `cfg_stream`=1 (continuous), `in_ready` stays high right after a frame is loaded, so the next frame loads while the first is computed and drained. Both frames come out correct.
- R6: While `out_valid`=1 and `out_ready`=0, the next cycle still has `out_valid`=1 with unchanged `out_re`/`out_im`.
- R7: A configuration write (`cfg_we`=1) is accepted only when no sample is buffered, partly loaded, in flight or being drained. Any other write is ignored and sets `cfg_err`, which stays set until reset.
- R8: A write with `cfg_log2n` below 3 or above the build limit `LOG_MAX` is ignored, and it sets `cfg_err`.
- R9: After reset: `in_ready`=1, `out_valid`=0, `done`=0, `cfg_err`=0. The configuration is L=3, forward, decimation in time, discrete.
- R10: In discrete mode, `out_valid` first rises (L·N/2)+1 clock edges after the edge of the final input beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_log2n | input | 4 | Length exponent L, N = 2^L |
| cfg_inverse | input | 1 | 1 = inverse transform |
| cfg_dif | input | 1 | 1 = decimation in frequency, 0 = in time |
| cfg_stream | input | 1 | 1 = continuous (two buffers), 0 = discrete |
| cfg_err | output | 1 | Sticky flag for rejected configuration writes |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine can take an input sample |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the output sample |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest state to reach from the ports is the continuous-mode overlap: one buffer is being loaded while the other is still in its butterfly stages or draining. This only happens if a second frame arrives before the first has left. The stimulus therefore runs the sender and the receiver as parallel threads, and compares both frames against a DFT computed in the bench. A configuration write that lands mid-computation is equally narrow. It is issued straight after a frame has been loaded, and the bench then confirms that the frame still returns the old length and the correct values.

// File: rtl/fft_pkg.sv
package fft_pkg;

  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] re;
    logic signed [SAMPLE_W-1:0] im;
  } cplx_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COMP,
    ST_DRAIN
  } eng_state_e;

endpackage

// File: rtl/fft_twiddle.sv
module fft_twiddle #(
  parameter int LOG_MAX = 6,
  parameter int TW_W    = 16
) (
  input  logic [LOG_MAX-2:0]       k,
  input  logic                     inverse,
  output logic signed [TW_W-1:0]   w_re,
  output logic signed [TW_W-1:0]   w_im
);
  localparam int M  = 1 << LOG_MAX;
  localparam int Q  = M / 4;
  localparam int KW = LOG_MAX - 1;

  function automatic logic signed [TW_W-1:0] cos_q(input int m);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(m) / real'(M);
    v   = $cos(ang) * (2.0 ** (TW_W - 2));
    return TW_W'($rtoi(v + 0.5));
  endfunction

  logic signed [TW_W-1:0] tab [Q+1];

  for (genvar g = 0; g <= Q; g++) begin : g_tab
    localparam logic signed [TW_W-1:0] ENTRY = cos_q(g);
    assign tab[g] = ENTRY;
  end

  logic signed [TW_W-1:0] c_v, s_v;
  logic [KW-1:0] k2;

  always_comb begin
    k2 = '0;
    if (k < KW'(Q)) begin
      c_v = tab[k];
      s_v = tab[KW'(Q) - k];
    end else begin
      k2  = k - KW'(Q);
      c_v = -tab[KW'(Q) - k2];
      s_v = tab[k2];
    end
    w_re = c_v;
    w_im = inverse ? s_v : -s_v;
  end

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic              dif,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = DW + TW + 3;
  localparam logic signed [PW-1:0] RND_T = PW'(1) <<< (TW - 3);
  localparam logic signed [PW-1:0] RND_D = PW'(1) <<< (TW - 2);
  localparam logic signed [PW-1:0] MAXV  = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV  = -MAXV - PW'(1);

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > MAXV)      return DW'(MAXV);
    else if (v < MINV) return DW'(MINV);
    else               return v[DW-1:0];
  endfunction

  logic signed [PW-1:0] ar, ai, br, bi, wr, wi;
  logic signed [PW-1:0] t_re, t_im, d_re, d_im;

  always_comb begin
    ar = PW'(a_re);
    ai = PW'(a_im);
    br = PW'(b_re);
    bi = PW'(b_im);
    wr = PW'(w_re);
    wi = PW'(w_im);
    t_re = '0;
    t_im = '0;
    d_re = '0;
    d_im = '0;
    if (!dif) begin
      // rotate first, then add/subtract, then halve
      t_re = (br * wr - bi * wi + RND_T) >>> (TW - 2);
      t_im = (br * wi + bi * wr + RND_T) >>> (TW - 2);
      x_re = sat((ar + t_re + PW'(1)) >>> 1);
      x_im = sat((ai + t_im + PW'(1)) >>> 1);
      y_re = sat((ar - t_re + PW'(1)) >>> 1);
      y_im = sat((ai - t_im + PW'(1)) >>> 1);
    end else begin
      // add/subtract first, rotate the difference, halving folded into shift
      d_re = ar - br;
      d_im = ai - bi;
      x_re = sat((ar + br + PW'(1)) >>> 1);
      x_im = sat((ai + bi + PW'(1)) >>> 1);
      y_re = sat((d_re * wr - d_im * wi + RND_D) >>> (TW - 1));
      y_im = sat((d_re * wi + d_im * wr + RND_D) >>> (TW - 1));
    end
  end

endmodule

// File: rtl/fft_engine.sv
module fft_engine
  import fft_pkg::*;
#(
  parameter int LOG_MAX = 6,
  parameter int TW_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_log2n,
  input  logic                       cfg_inverse,
  input  logic                       cfg_dif,
  input  logic                       cfg_stream,
  output logic                       cfg_err,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_re,
  input  logic signed [SAMPLE_W-1:0] in_im,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_re,
  output logic signed [SAMPLE_W-1:0] out_im,
  output logic                       done
);
  localparam int NMAX = 1 << LOG_MAX;
  localparam int AW   = LOG_MAX;
  localparam int KW   = LOG_MAX - 1;

  // active configuration
  logic [3:0] act_l;
  logic       act_inv, act_dif, act_stream;

  // buffer bookkeeping
  logic [1:0]    full_q;
  logic          lb_q, eb_q;
  logic [AW-1:0] ld_cnt, rd_cnt, j_q;
  logic [3:0]    stage_q;
  eng_state_e    st_q;

  cplx_t bank_q [2][NMAX];

  function automatic logic [AW-1:0] brev(input logic [AW-1:0] v, input logic [3:0] l);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r >> (4'(AW) - l);
  endfunction

  logic [AW:0]   nval;
  logic [AW-1:0] n_m1, half_m1;
  logic          in_fire, out_fire, eng_idle;

  assign nval     = (AW+1)'(1) << act_l;
  assign n_m1     = AW'(nval - (AW+1)'(1));
  assign half_m1  = AW'((nval >> 1) - (AW+1)'(1));
  assign in_ready = act_stream ? !full_q[lb_q] : (full_q == 2'b00);
  assign in_fire  = in_valid && in_ready;
  assign out_valid = (st_q == ST_DRAIN);
  assign out_fire = out_valid && out_ready;
  assign eng_idle = (full_q == 2'b00) && (ld_cnt == '0) && (st_q == ST_IDLE);

  // butterfly addressing
  logic [3:0]    sl;
  logic [AW-1:0] span, pos, a_addr, b_addr, tw_tmp, ld_addr, rd_addr;
  logic [KW-1:0] tw_k;

  always_comb begin
    sl     = act_dif ? (act_l - 4'd1 - stage_q) : stage_q;
    span   = AW'(1) << sl;
    pos    = j_q & (span - AW'(1));
    a_addr = ((j_q >> sl) << (sl + 4'd1)) | pos;
    b_addr = a_addr | span;
    tw_tmp = pos << (4'(KW) - sl);
    tw_k   = tw_tmp[KW-1:0];
    ld_addr = act_dif ? ld_cnt : brev(ld_cnt, act_l);
    rd_addr = act_dif ? brev(rd_cnt, act_l) : rd_cnt;
  end

  cplx_t a_val, b_val, bf_x, bf_y, rd_val;
  logic signed [TW_W-1:0] w_re, w_im;

  assign a_val  = bank_q[eb_q][a_addr];
  assign b_val  = bank_q[eb_q][b_addr];
  assign rd_val = bank_q[eb_q][rd_addr];
  assign out_re = rd_val.re;
  assign out_im = rd_val.im;

  fft_twiddle #(.LOG_MAX(LOG_MAX), .TW_W(TW_W)) u_tw (
    .k       (tw_k),
    .inverse (act_inv),
    .w_re    (w_re),
    .w_im    (w_im)
  );

  fft_butterfly #(.DW(SAMPLE_W), .TW(TW_W)) u_bf (
    .dif  (act_dif),
    .a_re (a_val.re),
    .a_im (a_val.im),
    .b_re (b_val.re),
    .b_im (b_val.im),
    .w_re (w_re),
    .w_im (w_im),
    .x_re (bf_x.re),
    .x_im (bf_x.im),
    .y_re (bf_y.re),
    .y_im (bf_y.im)
  );

  // sample storage: loader writes one bank, butterfly rewrites the other
  always_ff @(posedge clk) begin
    if (in_fire) bank_q[lb_q][ld_addr] <= '{re: in_re, im: in_im};
    if (st_q == ST_COMP) begin
      bank_q[eb_q][a_addr] <= bf_x;
      bank_q[eb_q][b_addr] <= bf_y;
    end
  end

  // configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_l      <= 4'd3;
      act_inv    <= 1'b0;
      act_dif    <= 1'b0;
      act_stream <= 1'b0;
      cfg_err    <= 1'b0;
    end else if (cfg_we) begin
      if (eng_idle && cfg_log2n >= 4'd3 && cfg_log2n <= 4'(LOG_MAX)) begin
        act_l      <= cfg_log2n;
        act_inv    <= cfg_inverse;
        act_dif    <= cfg_dif;
        act_stream <= cfg_stream;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

  // loader
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_cnt <= '0;
      lb_q   <= 1'b0;
    end else if (in_fire) begin
      if (ld_cnt == n_m1) begin
        ld_cnt <= '0;
        lb_q   <= !lb_q;
      end else begin
        ld_cnt <= ld_cnt + AW'(1);
      end
    end
  end

  // compute and drain sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      eb_q    <= 1'b0;
      full_q  <= 2'b00;
      stage_q <= '0;
      j_q     <= '0;
      rd_cnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_fire && ld_cnt == n_m1) full_q[lb_q] <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (full_q[eb_q]) begin
            st_q    <= ST_COMP;
            stage_q <= '0;
            j_q     <= '0;
          end
        end
        ST_COMP: begin
          if (j_q == half_m1) begin
            j_q <= '0;
            if (stage_q == act_l - 4'd1) begin
              st_q   <= ST_DRAIN;
              rd_cnt <= '0;
            end else begin
              stage_q <= stage_q + 4'd1;
            end
          end else begin
            j_q <= j_q + AW'(1);
          end
        end
        ST_DRAIN: begin
          if (out_fire) begin
            if (rd_cnt == n_m1) begin
              full_q[eb_q] <= 1'b0;
              eb_q         <= !eb_q;
              st_q         <= ST_IDLE;
              done         <= 1'b1;
            end else begin
              rd_cnt <= rd_cnt + AW'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fft_engine_sva.sv
module fft_engine_sva #(
  parameter int LOG_MAX = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_log2n,
  input logic        cfg_err,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_re,
  input logic [15:0] out_im,
  input logic        done,
  input logic        mode_stream
);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_bad_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_log2n < 4'd3 || cfg_log2n > 4'(LOG_MAX))) |=> cfg_err);

  assert_discrete_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_stream && out_valid) |-> !in_ready);

endmodule

bind fft_engine fft_engine_sva #(.LOG_MAX(LOG_MAX)) i_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_log2n   (cfg_log2n),
  .cfg_err     (cfg_err),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_re      (out_re),
  .out_im      (out_im),
  .done        (done),
  .mode_stream (act_stream)
);

// File: tb/test_fft_engine.sv
`timescale 1ns/1ps
module test_fft_engine;
  localparam int LM   = 6;
  localparam int NMX  = 1 << LM;
  localparam real TOL = 3.0;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_log2n = 4'd3;
  logic cfg_inverse = 1'b0, cfg_dif = 1'b0, cfg_stream = 1'b0;
  logic cfg_err;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_re, out_im;
  logic done;

  fft_engine #(.LOG_MAX(LM), .TW_W(16)) i_fft_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_log2n(cfg_log2n),
    .cfg_inverse(cfg_inverse), .cfg_dif(cfg_dif), .cfg_stream(cfg_stream),
    .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .done(done)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int xr [NMX];
  int xi [NMX];
  int yr [NMX];
  int yi [NMX];

  // {L[31:28], inverse[27], dif[26], kind[25:24], freq/pos[23:16], amp[15:0]}
  // kind 0 = impulse at pos, 1 = constant, 2 = complex tone at bin freq
  localparam logic [31:0] VECS [8] = '{
    {4'd3, 1'b0, 1'b0, 2'd0, 8'd0, 16'd8000},
    {4'd3, 1'b0, 1'b1, 2'd0, 8'd3, 16'd8000},
    {4'd4, 1'b0, 1'b0, 2'd1, 8'd0, 16'd2000},
    {4'd5, 1'b0, 1'b1, 2'd2, 8'd3, 16'd4000},
    {4'd6, 1'b0, 1'b0, 2'd2, 8'd5, 16'd6000},
    {4'd6, 1'b1, 1'b1, 2'd2, 8'd7, 16'd5000},
    {4'd4, 1'b1, 1'b0, 2'd0, 8'd5, 16'd8000},
    {4'd5, 1'b0, 1'b0, 2'd0, 8'd1, 16'd8000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input int l, input bit inv, input bit dif, input bit str);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_log2n = 4'(l);
    cfg_inverse = inv;
    cfg_dif = dif;
    cfg_stream = str;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic gen(input int kind, input int f, input int amp, input int n);
    for (int i = 0; i < n; i++) begin
      real th;
      th = 2.0 * PI * real'(f) * real'(i) / real'(n);
      case (kind)
        0: begin xr[i] = (i == f) ? amp : 0; xi[i] = 0; end
        1: begin xr[i] = amp; xi[i] = 0; end
        default: begin
          xr[i] = int'(real'(amp) * $cos(th));
          xi[i] = int'(real'(amp) * $sin(th));
        end
      endcase
    end
  endtask

  // returns at the negedge after the final input beat
  task automatic tx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = 16'(xr[i]);
      in_im = 16'(xi[i]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rx(input int n, input bit bp);
    int k = 0;
    int cyc = 0;
    bit held = 1'b0;
    int hr = 0, hi = 0;
    while (k < n) begin
      @(negedge clk);
      if (held) begin
        chk(out_valid && out_re == 16'(hr) && out_im == 16'(hi), "R6",
            "held beat changed", int'(out_re), hr);
        held = 1'b0;
      end
      out_ready = !bp || (cyc % 3 != 0);
      cyc++;
      if (out_valid && out_ready) begin
        yr[k] = int'(out_re);
        yi[k] = int'(out_im);
        k++;
      end else if (out_valid) begin
        held = 1'b1;
        hr = int'(out_re);
        hi = int'(out_im);
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done == 1'b1, "R1", "done after last beat", int'(done), 1);
    chk(out_valid == 1'b0, "R1", "extra output beat", int'(out_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done width", int'(done), 0);
  endtask

  task automatic cmp(input int n, input bit inv, input string req);
    real worst = 0.0;
    int wa = 0, we = 0;
    for (int k = 0; k < n; k++) begin
      real rr = 0.0, ri = 0.0, s, e;
      s = inv ? 1.0 : -1.0;
      for (int i = 0; i < n; i++) begin
        real th;
        th = 2.0 * PI * real'(i) * real'(k) / real'(n);
        rr += real'(xr[i]) * $cos(th) - s * real'(xi[i]) * $sin(th);
        ri += real'(xi[i]) * $cos(th) + s * real'(xr[i]) * $sin(th);
      end
      rr /= real'(n);
      ri /= real'(n);
      e = (real'(yr[k]) - rr);
      if (e < 0.0) e = -e;
      if (e > worst) begin worst = e; wa = yr[k]; we = int'(rr); end
      e = (real'(yi[k]) - ri);
      if (e < 0.0) e = -e;
      if (e > worst) begin worst = e; wa = yi[k]; we = int'(ri); end
    end
    chk(worst <= TOL, req, $sformatf("frame N=%0d worst bin", n), wa, we);
  endtask

  initial begin
    do_reset();
    // R9: reset values
    chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
    chk(cfg_err == 1'b0, "R9", "cfg_err after reset", int'(cfg_err), 0);
    // R9: default configuration is an 8-point forward transform
    gen(2, 1, 4000, 8);
    tx(8);
    rx(8, 1'b0);
    cmp(8, 1'b0, "R9");

    // vector table
    for (int v = 0; v < 8; v++) begin
      int l, n;
      bit inv, dif;
      l = int'(VECS[v][31:28]);
      inv = VECS[v][27];
      dif = VECS[v][26];
      n = 1 << l;
      cfg(l, inv, dif, 1'b0);
      gen(int'(VECS[v][25:24]), int'(VECS[v][23:16]), int'(VECS[v][15:0]), n);
      tx(n);
      rx(n, v[0]);
      cmp(n, inv, inv ? "R3" : (dif ? "R4" : "R2"));
    end

    // R5 / R10: discrete blocking and latency, L=4
    cfg(4, 1'b0, 1'b0, 1'b0);
    gen(0, 2, 8000, 16);
    tx(16);
    chk(in_ready == 1'b0, "R5", "discrete in_ready after load", int'(in_ready), 0);
    begin
      int cnt = 0;
      while (!out_valid && cnt < 1000) begin
        @(posedge clk);
        cnt++;
        @(negedge clk);
      end
      chk(cnt == 33, "R10", "edges to first output", cnt, 33);
    end
    rx(16, 1'b0);
    cmp(16, 1'b0, "R10");

    // R7: configuration write while computing is ignored
    gen(2, 3, 5000, 16);
    tx(16);
    cfg(3, 1'b1, 1'b1, 1'b0);
    chk(cfg_err == 1'b1, "R7", "error after busy write", int'(cfg_err), 1);
    rx(16, 1'b0);
    cmp(16, 1'b0, "R7");
    chk(cfg_err == 1'b1, "R7", "error sticky", int'(cfg_err), 1);

    // R8: out-of-range lengths
    do_reset();
    cfg(2, 1'b0, 1'b0, 1'b0);
    chk(cfg_err == 1'b1, "R8", "error on L=2", int'(cfg_err), 1);
    cfg(LM + 1, 1'b0, 1'b0, 1'b0);
    gen(0, 4, 8000, 8);
    tx(8);
    rx(8, 1'b0);
    cmp(8, 1'b0, "R8");

    // R5: continuous mode, second frame loads during the first
    do_reset();
    cfg(3, 1'b0, 1'b1, 1'b1);
    gen(2, 2, 6000, 8);
    fork
      begin
        tx(8);
        chk(in_ready == 1'b1, "R5", "continuous in_ready after load", int'(in_ready), 1);
        tx(8);
      end
      begin
        rx(8, 1'b0);
        cmp(8, 1'b0, "R5");
        rx(8, 1'b1);
        cmp(8, 1'b0, "R5");
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule